// File: doc/BRIEF.md
# SPI Boot Image Loader

After reset, this block acts as an SPI master and copies a boot image from an external serial EEPROM or flash into system memory. A two-bit strap gives the width of the memory address, or turns booting off. The loader first reads the first 16 bytes of the image at a slow fixed clock rate. Those bytes hold the start of a 32-word header. From them the loader learns the image length, a new clock divisor and whether the device can do a high-speed read.

It then deselects the device and starts a second read at byte 16, using the new rate and the read command that fits the device. It delivers every byte of the image, the header included, as little-endian 32-bit words on a simple memory-write port. Two further header words, the SDRAM mode word and the memory config word, are held on outputs for a later boot stage. The block ends in a done state, or in an error state when the length field is too small.

Top module: `spi_boot_loader`

## Requirements
- R1: With `bootMode` = 00 the block reaches done without ever driving `csN` low.
- R2: The address sent after the opcode is 1, 2 or 3 bytes long, MSB first, for `bootMode` 01, 10 or 11. The first read starts at byte address 0 and the second read starts at byte address 16.
- R3: The first read uses opcode 0x03, and its SCLK period is 2×(SLOW_DIV+1) clock cycles.
- R4: The second read runs with an SCLK period of 2×(D+1) clock cycles, where D is bits [9:0] of header word 2. Bits [31:10] of that word have no effect.
- R5: If bit 0 of header word 3 is 1, the second read uses opcode 0x0B and puts one dummy byte after the address. If the bit is 0, the second read uses opcode 0x03 with no dummy byte. Bits [31:1] of that word have no effect.
- R6: The SPI link runs in mode 0. SCLK idles low, MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and every byte is sent MSB first.
- R7: Received bytes are packed little-endian into words, with the first byte of a word in bits [7:0]. Each word is written with a one-cycle `memWrEn` pulse. Word addresses run 0, 1, 2, … from the start of the header.
- R8: The number of words written is bits [19:0] of header word 0. Bits [31:20] of that word are ignored.
- R9: If the length field is below 32, zero included, the block raises `error` after the first 4 words. It then stops, never selects the device again, and never raises `done`.
- R10: `csN` goes high for at least one cycle between the two reads. SCLK stays low whenever `csN` is high.
- R11: `done` rises with the last word write, and `csN` is then high. `sdramMode` equals header word 1 bits [27:0], and `memConfig` equals header word 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootMode | input | 2 | Strap: 00 off, 01/10/11 = 1/2/3 address bytes |
| miso | input | 1 | Serial data from the memory device |
| sclk | output | 1 | SPI clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the memory device |
| memWrEn | output | 1 | One-cycle write strobe |
| memWrAddr | output | 20 | Word address of the write |
| memWrData | output | 32 | Word being written |
| sdramMode | output | 28 | Captured SDRAM mode word |
| memConfig | output | 32 | Captured memory config word |
| done | output | 1 | Image fully loaded, or boot disabled |
| error | output | 1 | Header length field invalid |

## Verification
Two pairs of events share a single clock edge:
- The write of the last word lands on the same edge on which `done` rises.
- The capture of the high-speed bit from word 3 lands on the same edge on which the loader deselects the device and makes the decision about the second command.

Every image is sized so that the last word ends the transfer. The bench samples the write port half a cycle after each edge, so it must count that final write even as `done` rises. Judging the second pair, images are run with the high-speed bit both set and clear. The opcode, the presence of the dummy byte (seen in the data alignment) and the SCLK period captured by the memory model in the second session must all follow the header value fetched just before.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam int DIV_W      = 10;
  localparam int SIZE_W     = 20;
  localparam int HDR_WORDS  = 32;
  localparam int SLOW_WORDS = 4;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;

  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
    logic       isData;
    logic       loadFast;
  } dpCmd_t;
endpackage

// File: rtl/spi_boot_shifter.sv
module spi_boot_shifter #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       txByte,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             byteDone,
  output logic [7:0]       rxByte
);
  logic [DIV_W-1:0] halfCnt;
  logic [3:0]       edgeCnt;
  logic             sclkR, busyR, doneR;
  logic [7:0]       txSh, rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      edgeCnt <= '0;
      sclkR   <= 1'b0;
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      doneR <= 1'b0;
      if (!busyR) begin
        if (start) begin
          busyR   <= 1'b1;
          txSh    <= txByte;
          halfCnt <= '0;
          edgeCnt <= '0;
          sclkR   <= 1'b0;
        end
      end else if (halfCnt == halfDiv) begin
        halfCnt <= '0;
        sclkR   <= ~sclkR;
        edgeCnt <= edgeCnt + 4'd1;
        // rising edge samples, falling edge advances the output bit
        if (!sclkR) rxSh <= {rxSh[6:0], miso};
        else        txSh <= {txSh[6:0], 1'b0};
        if (edgeCnt == 4'd15) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = txSh[7];
  assign byteDone = doneR;
  assign rxByte   = rxSh;

  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && $past(sclkR)) |-> $stable(txSh[7]));

  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busyR);
endmodule

// File: rtl/spi_boot_dp.sv
module spi_boot_dp
  import spi_boot_pkg::*;
#(
  parameter int SLOW_DIV = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              byteDone,
  output logic              memWrEn,
  output logic [SIZE_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [SIZE_W-1:0] sizeWords,
  output logic              hsRead,
  output logic [27:0]       sdramMode,
  output logic [31:0]       memConfig
);
  logic [DIV_W-1:0]  curDiv, divHdr;
  logic [7:0]        rxByte;
  logic              dataLatch;
  logic [1:0]        byteIdx;
  logic [23:0]       wordSh;
  logic [SIZE_W-1:0] wordIdx;
  logic [31:0]       newWord;

  spi_boot_shifter #(.DIV_W(DIV_W)) shifter_i (
    .clk(clk), .rstN(rstN), .start(cmd.start), .txByte(cmd.txByte),
    .halfDiv(curDiv), .miso(miso), .sclk(sclk), .mosi(mosi),
    .byteDone(byteDone), .rxByte(rxByte)
  );

  assign newWord = {rxByte, wordSh};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDiv    <= DIV_W'(SLOW_DIV);
      divHdr    <= '0;
      dataLatch <= 1'b0;
      byteIdx   <= '0;
      wordSh    <= '0;
      wordIdx   <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      sizeWords <= '0;
      hsRead    <= 1'b0;
      sdramMode <= '0;
      memConfig <= '0;
    end else begin
      memWrEn <= 1'b0;
      if (cmd.start)    dataLatch <= cmd.isData;
      if (cmd.loadFast) curDiv    <= divHdr;
      if (byteDone && dataLatch) begin
        byteIdx <= byteIdx + 2'd1;
        if (byteIdx == 2'd3) begin
          memWrEn   <= 1'b1;
          memWrAddr <= wordIdx;
          memWrData <= newWord;
          wordIdx   <= wordIdx + 1'b1;
          case (wordIdx)
            SIZE_W'(0): sizeWords <= newWord[SIZE_W-1:0];
            SIZE_W'(1): sdramMode <= newWord[27:0];
            SIZE_W'(2): divHdr    <= newWord[DIV_W-1:0];
            SIZE_W'(3): hsRead    <= newWord[0];
            SIZE_W'(4): memConfig <= newWord;
            default: ;
          endcase
        end else begin
          wordSh <= {rxByte, wordSh[23:8]};
        end
      end
    end
  end

  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);
endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
  import spi_boot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bootMode,
  input  logic              byteDone,
  input  logic [SIZE_W-1:0] sizeWords,
  input  logic              hsRead,
  output dpCmd_t            cmd,
  output logic              csN,
  output logic              done,
  output logic              error
);
  localparam int CNT_W = SIZE_W + 2;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_GAP, S_DONE, S_ERR
  } state_t;

  state_t           state;
  logic             waitB, secondPass, active, sizeOk, fastCmd;
  logic [1:0]       nAddr, addrCnt;
  logic [CNT_W-1:0] bytesLeft;

  assign active  = state inside {S_CMD, S_ADDR, S_DUMMY, S_DATA};
  assign sizeOk  = sizeWords >= SIZE_W'(HDR_WORDS);
  assign fastCmd = secondPass && hsRead;

  always_comb begin
    cmd       = '0;
    cmd.start = active && !waitB;
    case (state)
      S_CMD:  cmd.txByte = fastCmd ? OP_FAST : OP_READ;
      S_ADDR: cmd.txByte = (secondPass && addrCnt == nAddr - 2'd1)
                           ? 8'(SLOW_WORDS * 4) : 8'h00;
      S_DATA: cmd.isData = 1'b1;
      S_GAP:  cmd.loadFast = sizeOk;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      waitB      <= 1'b0;
      secondPass <= 1'b0;
      nAddr      <= '0;
      addrCnt    <= '0;
      bytesLeft  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          nAddr <= bootMode;
          state <= (bootMode == 2'b00) ? S_DONE : S_CMD;
        end
        S_GAP: begin
          if (!sizeOk) begin
            state <= S_ERR;
          end else begin
            secondPass <= 1'b1;
            state      <= S_CMD;
          end
        end
        S_DONE, S_ERR: ;
        default: begin
          if (!waitB) begin
            waitB <= 1'b1;
          end else if (byteDone) begin
            waitB <= 1'b0;
            case (state)
              S_CMD: begin
                addrCnt <= '0;
                state   <= S_ADDR;
              end
              S_ADDR: begin
                if (addrCnt == nAddr - 2'd1) begin
                  state     <= fastCmd ? S_DUMMY : S_DATA;
                  bytesLeft <= secondPass
                               ? {sizeWords - SIZE_W'(SLOW_WORDS), 2'b00}
                               : CNT_W'(SLOW_WORDS * 4);
                end else begin
                  addrCnt <= addrCnt + 2'd1;
                end
              end
              S_DUMMY: state <= S_DATA;
              default: begin
                bytesLeft <= bytesLeft - 1'b1;
                if (bytesLeft == CNT_W'(1))
                  state <= secondPass ? S_DONE : S_GAP;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign csN   = !active;
  assign done  = (state == S_DONE);
  assign error = (state == S_ERR);
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int SLOW_DIV = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bootMode,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  output logic              memWrEn,
  output logic [SIZE_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [27:0]       sdramMode,
  output logic [31:0]       memConfig,
  output logic              done,
  output logic              error
);
  dpCmd_t            cmd;
  logic              byteDone, hsRead;
  logic [SIZE_W-1:0] sizeWords;

  spi_boot_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bootMode(bootMode), .byteDone(byteDone),
    .sizeWords(sizeWords), .hsRead(hsRead), .cmd(cmd), .csN(csN),
    .done(done), .error(error)
  );

  spi_boot_dp #(.SLOW_DIV(SLOW_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso), .sclk(sclk),
    .mosi(mosi), .byteDone(byteDone), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .sizeWords(sizeWords),
    .hsRead(hsRead), .sdramMode(sdramMode), .memConfig(memConfig)
  );

  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !sclk));
endmodule

// File: tb/spi_boot_loader_tb_top.sv
module spi_boot_loader_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SLOW_DIV = 7;
  localparam int NV = 4;
  localparam logic [1:0]  V_MODE [NV] = '{2'd1, 2'd2, 2'd3, 2'd3};
  localparam logic [31:0] V_W0   [NV] = '{32'd32, 32'd34, 32'd33, 32'hFFF00020};
  localparam logic [9:0]  V_DIV  [NV] = '{10'd1, 10'd0, 10'd2, 10'd0};
  localparam logic        V_HS   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] bootMode = 2'b00;
  logic miso = 1'b0;
  logic sclk, csN, mosi, memWrEn, done, error;
  logic [19:0] memWrAddr;
  logic [31:0] memWrData, memConfig;
  logic [27:0] sdramMode;

  always #2.5 clk = ~clk;

  spi_boot_loader #(.SLOW_DIV(SLOW_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .bootMode(bootMode), .miso(miso), .sclk(sclk),
    .csN(csN), .mosi(mosi), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .sdramMode(sdramMode), .memConfig(memConfig),
    .done(done), .error(error)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] curW0;
  logic [9:0]  curDiv;
  logic        curHs;
  int          caseId;

  function automatic logic [31:0] imgWord(int i);
    case (i)
      0: return curW0;
      1: return {4'hA, 28'h0022000 + 28'(caseId)};
      2: return 32'hABC00000 | 32'(curDiv);
      3: return 32'h55555554 | 32'(curHs);
      4: return 32'hC0FFEE00 ^ 32'(caseId);
      default: return {8'(caseId), 8'h5A, 16'(i)} ^ 32'h0F0F0000;
    endcase
  endfunction

  function automatic logic [7:0] memByte(int a);
    logic [31:0] w;
    w = imgWord(a / 4);
    return 8'(w >> (8 * (a % 4)));
  endfunction

  // behavioural serial memory, one process
  int bitCnt = 0;
  int csFalls = 0;
  logic [63:0] rxBits = '0;
  logic [7:0] sessOp [4];
  int sessAddr [4];
  int sessRise1 [4];
  int sessRise2 [4];
  logic lastSclk = 1'b0;
  logic lastCs = 1'b1;

  always @(posedge clk) cyc = cyc + 1;

  always @(sclk or csN) begin
    int s, hdrBits, d;
    s = (csFalls < 4) ? csFalls : 3;
    if (csN === 1'b0 && lastCs === 1'b1) begin
      csFalls = csFalls + 1;
      bitCnt = 0;
    end else if (csN === 1'b0 && sclk === 1'b1 && lastSclk === 1'b0) begin
      rxBits = {rxBits[62:0], mosi};
      bitCnt = bitCnt + 1;
      if (bitCnt == 1) sessRise1[s] = cyc;
      if (bitCnt == 2) sessRise2[s] = cyc;
      if (bitCnt == 8) sessOp[s] = rxBits[7:0];
      if (bitCnt == 8 * (1 + int'(bootMode)))
        sessAddr[s] = int'(rxBits[31:0] & ((32'h1 << (8 * int'(bootMode))) - 32'h1));
    end else if (csN === 1'b0 && sclk === 1'b0 && lastSclk === 1'b1) begin
      hdrBits = 8 * (1 + int'(bootMode) + ((sessOp[s] == 8'h0B) ? 1 : 0));
      if (bitCnt >= hdrBits) begin
        d = bitCnt - hdrBits;
        miso = memByte(sessAddr[s] + d / 8)[7 - (d % 8)];
      end
    end
    lastSclk = sclk;
    lastCs = csN;
  end

  // write port monitor, sampled half a cycle after the edge
  int wrCount = 0;
  int wrBad = 0;
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (int'(memWrAddr) != wrCount || memWrData != imgWord(int'(memWrAddr))) begin
        wrBad = wrBad + 1;
        $display("FAIL R7 word write actual addr=%0d data=%h expected addr=%0d data=%h",
                 memWrAddr, memWrData, wrCount, imgWord(wrCount));
      end
      wrCount = wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startCase(input logic [1:0] mode, input logic [31:0] w0,
                           input logic [9:0] dv, input logic hs, input int id);
    rstN = 1'b0;
    bootMode = mode;
    curW0 = w0; curDiv = dv; curHs = hs; caseId = id;
    repeat (4) @(negedge clk);
    csFalls = 0; wrCount = 0; wrBad = 0; bitCnt = 0;
    for (int k = 0; k < 4; k++) begin
      sessOp[k] = 8'h00; sessAddr[k] = -1; sessRise1[k] = 0; sessRise2[k] = 0;
    end
    rstN = 1'b1;
  endtask

  task automatic waitEnd(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 30000; n++) begin
      @(negedge clk);
      if (done || error) begin ok = 1'b1; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    // reset state
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b0, "R10", "reset csN/sclk", {csN, sclk}, 2'b10);
    check(done === 1'b0 && error === 1'b0 && memWrEn === 1'b0, "R11", "reset flags",
          {done, error, memWrEn}, 0);

    // table of images
    for (int v = 0; v < NV; v++) begin
      startCase(V_MODE[v], V_W0[v], V_DIV[v], V_HS[v], v + 1);
      waitEnd(ok);
      check(ok, "R11", "finished", ok, 1);
      check(done === 1'b1 && error === 1'b0, "R11", "done flag", {done, error}, 2'b10);
      check(wrCount == int'(V_W0[v][19:0]), "R8", "word count", wrCount, V_W0[v][19:0]);
      check(wrBad == 0, "R7", "words match (R6 bit order)", wrBad, 0);
      check(csFalls == 2, "R10", "two selections", csFalls, 2);
      check(sessOp[1] == 8'h03, "R3", "first opcode", sessOp[1], 8'h03);
      check(sessAddr[1] == 0, "R2", "first address", sessAddr[1], 0);
      check(sessAddr[2] == 16, "R2", "second address", sessAddr[2], 16);
      check(sessRise2[1] - sessRise1[1] == 2 * (SLOW_DIV + 1), "R3", "slow period",
            sessRise2[1] - sessRise1[1], 2 * (SLOW_DIV + 1));
      check(sessRise2[2] - sessRise1[2] == 2 * (int'(V_DIV[v]) + 1), "R4", "fast period",
            sessRise2[2] - sessRise1[2], 2 * (int'(V_DIV[v]) + 1));
      check(sessOp[2] == (V_HS[v] ? 8'h0B : 8'h03), "R5", "second opcode",
            sessOp[2], V_HS[v] ? 8'h0B : 8'h03);
      check(sdramMode == imgWord(1)[27:0], "R11", "sdram mode word", sdramMode, imgWord(1)[27:0]);
      check(memConfig == imgWord(4), "R11", "config word", memConfig, imgWord(4));
      check(csN === 1'b1, "R11", "deselected at end", csN, 1);
    end

    // strap off
    startCase(2'b00, 32'd32, 10'd0, 1'b0, 9);
    repeat (4) @(negedge clk);
    check(done === 1'b1, "R1", "strap off done", done, 1);
    repeat (50) @(negedge clk);
    check(csFalls == 0 && wrCount == 0, "R1", "strap off no activity", csFalls, 0);

    // length too small, then zero
    startCase(2'b10, 32'd16, 10'd0, 1'b1, 10);
    waitEnd(ok);
    check(error === 1'b1 && done === 1'b0, "R9", "short size error", {done, error}, 2'b01);
    check(csFalls == 1 && wrCount == 4, "R9", "short size stops", csFalls * 100 + wrCount, 104);
    repeat (200) @(negedge clk);
    check(csFalls == 1 && done === 1'b0, "R9", "stays stopped", csFalls, 1);

    startCase(2'b01, 32'h00000000, 10'd0, 1'b0, 11);
    waitEnd(ok);
    check(error === 1'b1 && done === 1'b0, "R9", "zero size error", {done, error}, 2'b01);
    check(csFalls == 1 && wrCount == 4, "R9", "zero size stops", csFalls * 100 + wrCount, 104);

    $display("CHECKS %0d ERRORS %0d", checks, errors + wrBad);
    $finish;
  end
endmodule